// File: doc/BRIEF.md
# Tile-Based Playfield Video Generator

This block turns a character-cell map into a serial playfield pixel stream. The screen is a grid of cells, each 8 pixels across and 8 scan lines tall, and each cell is drawn from one stored byte. A processor fills the map through a simple write port during its own half of the phase clock. During the other half, the incoming horizontal and vertical video counters address the map instead.

Once per cell, the byte read from the map is latched. Its low five bits choose one of 32 eight-row patterns in an internal picture ROM. Bit 6 mirrors the cell top-to-bottom by inverting the three row-select lines. The selected ROM row is loaded into a shift register and sent out one bit per pixel clock, leftmost pixel first. A blank input forces the output dark.

Counter generation, moving-object video, colour mixing and monitor timing are handled elsewhere. This block only consumes the counters and produces the one-bit playfield video.

Top module: `tile_playfield_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the shift register and the latched cell state clear, so `pix_out` reads 0 after reset.
- R2: A map byte at address `cpu_addr` (cell row × 32 + cell column) is written with `cpu_data` at a rising edge where `cpu_phase` is 0 and `cpu_wr_n` is 0.
- R3: A write strobe (`cpu_wr_n` = 0) at an edge where `cpu_phase` is 1 leaves the map unchanged.
- R4: At each edge where `cpu_phase` is 1, the map is read at {`vcnt[7:3]`, `hcnt[7:3]`}. At the edge where `hcnt[2:0]` = 1, the cell code read on the previous edge is latched, together with `vcnt[2:0]`. Between these latch edges the cell code holds.
- R5: Bits [4:0] of the cell code select the pattern p. ROM row r of pattern p is ((p×29) XOR (r×53) XOR 0xA5) mod 256, with bit 7 being the leftmost pixel.
- R6: When bit 6 of the cell code is 0, the ROM row used is `vcnt[2:0]`.
- R7: When bit 6 of the cell code is 1, the ROM row used is 7 − `vcnt[2:0]`, so the cell is drawn upside down.
- R8: At the edge where `hcnt[2:0]` = 2, the ROM row is loaded into the shift register. On every other edge it shifts left and fills with 0. After the edge at which `hcnt` = h (h ≥ 2), `pix_out` shows bit 7 − ((h−2) mod 8) of the row for cell column (h−2)/8.
- R9: While `blank` is 1, `pix_out` is 0 with no clock delay.
- R10: Bits 5 and 7 of a stored code have no effect on the pixels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_phase | input | 1 | Phase level: 0 = processor owns the map, 1 = video reads it |
| cpu_addr | input | 10 | Map write address, row × 32 + column |
| cpu_data | input | 8 | Cell code to write |
| cpu_wr_n | input | 1 | Active-low write strobe |
| hcnt | input | 8 | Horizontal video counter |
| vcnt | input | 8 | Vertical video counter |
| blank | input | 1 | Forces the pixel output to 0 |
| pix_out | output | 1 | Serial playfield pixel |

## Verification
The bench builds the block with its default geometry: a 32 × 32 map, five pattern-select bits and the mirror bit at position 6. With this geometry a full 256-pixel line covers every cell column, and a scan across all eight sub-rows of a cell row shows both the normal and the reversed row order. The stored codes are chosen so that both mirrored and unmirrored cells appear, and so that bits 5 and 7 vary; this makes the pattern selection, the mirroring and the ignored code bits visible at the pin. Dedicated scenarios then try a write during the video phase, repeat the same write during the processor phase, and assert blank across the middle of a line.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int CELL_LG  = 3;
    localparam int CELL_W   = 1 << CELL_LG;
    localparam int COL_LG   = 5;
    localparam int ROW_LG   = 5;
    localparam int H_W      = COL_LG + CELL_LG;
    localparam int V_W      = ROW_LG + CELL_LG;
    localparam int MAP_AW   = COL_LG + ROW_LG;
    localparam int MAP_DEPTH = 1 << MAP_AW;
    localparam int CODE_W   = 8;
    localparam int SEL_W    = 5;
    localparam int FLIP_BIT = 6;
    localparam int ROM_AW   = SEL_W + CELL_LG;
    localparam int ROM_DEPTH = 1 << ROM_AW;
    localparam int PIX_W    = CELL_W;

    localparam logic [CELL_LG-1:0] LATCH_PH = CELL_LG'(1);
    localparam logic [CELL_LG-1:0] LOAD_PH  = CELL_LG'(2);

    typedef struct packed {
        logic             flip;
        logic [SEL_W-1:0] sel;
    } cell_t;

    typedef logic [PIX_W-1:0] pix_row_t;

    function automatic pix_row_t pattern_row(input logic [SEL_W-1:0] sel,
                                             input logic [CELL_LG-1:0] row);
        logic [PIX_W-1:0] a;
        logic [PIX_W-1:0] b;
        a = PIX_W'(sel) * PIX_W'(29);
        b = PIX_W'(row) * PIX_W'(53);
        return a ^ b ^ PIX_W'(8'hA5);
    endfunction

    function automatic cell_t decode_code(input logic [CODE_W-1:0] code);
        cell_t c;
        c.flip = code[FLIP_BIT];
        c.sel  = code[SEL_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/pf_cell_map.sv
module pf_cell_map
    import pf_pkg::*;
(
    input  logic                    clk,
    input  logic                    cpu_phase,
    input  logic [MAP_AW-1:0]       cpu_addr,
    input  logic [CODE_W-1:0]       cpu_data,
    input  logic                    cpu_wr_n,
    input  logic [COL_LG-1:0]       cell_col,
    input  logic [ROW_LG-1:0]       cell_row,
    output logic                    we,
    output cell_t                   rd_cell
);

    logic [CODE_W-1:0] mem [MAP_DEPTH];
    logic [MAP_AW-1:0] vid_addr;
    logic [CODE_W-1:0] rd_byte;

    always_comb begin
        we       = !cpu_phase && !cpu_wr_n;
        vid_addr = {cell_row, cell_col};
        rd_byte  = mem[vid_addr];
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[cpu_addr] <= cpu_data;
        end
    end

    always_ff @(posedge clk) begin
        if (cpu_phase) begin
            rd_cell <= decode_code(rd_byte);
        end
    end

endmodule

// File: rtl/pf_pattern_rom.sv
module pf_pattern_rom
    import pf_pkg::*;
(
    input  logic [ROM_AW-1:0] addr,
    output pix_row_t          data
);

    pix_row_t rom [ROM_DEPTH];

    initial begin
        for (int i = 0; i < ROM_DEPTH; i++) begin
            rom[i] = pattern_row(SEL_W'(i >> CELL_LG), CELL_LG'(i));
        end
    end

    always_comb begin
        data = rom[addr];
    end

endmodule

// File: rtl/pf_cell_shifter.sv
module pf_cell_shifter
    import pf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cpu_phase,
    input  logic [CELL_LG-1:0]  hsub,
    input  logic [CELL_LG-1:0]  vsub,
    input  cell_t               rd_cell,
    input  pix_row_t            rom_data,
    output logic [ROM_AW-1:0]   rom_addr,
    output cell_t               cell_q,
    output pix_row_t            shreg
);

    logic [CELL_LG-1:0] row_q;
    logic [CELL_LG-1:0] row_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q <= '0;
            row_q  <= '0;
        end else if (cpu_phase && hsub == LATCH_PH) begin
            cell_q <= rd_cell;
            row_q  <= vsub;
        end
    end

    always_comb begin
        row_sel  = row_q ^ {CELL_LG{cell_q.flip}};
        rom_addr = {cell_q.sel, row_sel};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (hsub == LOAD_PH) begin
            shreg <= rom_data;
        end else begin
            shreg <= {shreg[PIX_W-2:0], 1'b0};
        end
    end

endmodule

// File: rtl/tile_playfield_gen.sv
module tile_playfield_gen
    import pf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_phase,
    input  logic [MAP_AW-1:0] cpu_addr,
    input  logic [CODE_W-1:0] cpu_data,
    input  logic              cpu_wr_n,
    input  logic [H_W-1:0]    hcnt,
    input  logic [V_W-1:0]    vcnt,
    input  logic              blank,
    output logic              pix_out
);

    logic              ram_we;
    cell_t             rd_cell;
    cell_t             cell_q;
    pix_row_t          rom_data;
    pix_row_t          shreg;
    logic [ROM_AW-1:0] rom_addr;

    pf_cell_map u_map (
        .clk       (clk),
        .cpu_phase (cpu_phase),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_wr_n  (cpu_wr_n),
        .cell_col  (hcnt[H_W-1:CELL_LG]),
        .cell_row  (vcnt[V_W-1:CELL_LG]),
        .we        (ram_we),
        .rd_cell   (rd_cell)
    );

    pf_pattern_rom u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    pf_cell_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .cpu_phase (cpu_phase),
        .hsub      (hcnt[CELL_LG-1:0]),
        .vsub      (vcnt[CELL_LG-1:0]),
        .rd_cell   (rd_cell),
        .rom_data  (rom_data),
        .rom_addr  (rom_addr),
        .cell_q    (cell_q),
        .shreg     (shreg)
    );

    always_comb begin
        pix_out = shreg[PIX_W-1] & ~blank;
    end

endmodule

// File: rtl/pf_checker.sv
module pf_checker
    import pf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_phase,
    input  logic [CELL_LG-1:0] hsub,
    input  logic               blank,
    input  logic               pix_out,
    input  logic               ram_we,
    input  cell_t              cell_q,
    input  pix_row_t           shreg
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (shreg == '0 && cell_q == '0)); // R1

    AST_VIDEO_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cpu_phase |-> !ram_we); // R3

    AST_CELL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(cpu_phase && hsub == LATCH_PH) |=> $stable(cell_q)); // R4

    AST_SHIFT_MSB: assert property (@(posedge clk) disable iff (rst)
        (hsub != LOAD_PH) |=> (shreg == {$past(shreg[PIX_W-2:0]), 1'b0})); // R8

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        blank |-> !pix_out); // R9

endmodule

bind tile_playfield_gen pf_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_phase (cpu_phase),
    .hsub      (hcnt[2:0]),
    .blank     (blank),
    .pix_out   (pix_out),
    .ram_we    (ram_we),
    .cell_q    (cell_q),
    .shreg     (shreg)
);

// File: tb/sim_tile_playfield_gen.sv
`timescale 1ns/1ps
module sim_tile_playfield_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpu_phase = 1'b0;
    logic [9:0] cpu_addr = '0;
    logic [7:0] cpu_data = '0;
    logic       cpu_wr_n = 1'b1;
    logic [7:0] hcnt = '0;
    logic [7:0] vcnt = '0;
    logic       blank = 1'b0;
    logic       pix_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] shadow [1024];

    always #10 clk = ~clk;

    tile_playfield_gen u0 (
        .clk(clk), .rst(rst), .cpu_phase(cpu_phase), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cpu_wr_n(cpu_wr_n), .hcnt(hcnt), .vcnt(vcnt),
        .blank(blank), .pix_out(pix_out)
    );

    function automatic logic [7:0] rom_row(input int p, input int r);
        return 8'((p * 29) ^ (r * 53) ^ 8'hA5);
    endfunction

    function automatic logic exp_pix(input int h, input int v);
        int hp, col, k, row;
        logic [7:0] code;
        hp   = h - 2;
        col  = hp / 8;
        k    = hp % 8;
        code = shadow[(v / 8) * 32 + col];
        row  = code[6] ? 7 - (v % 8) : (v % 8);
        return rom_row(int'(code[4:0]), row)[7 - k];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic cpu_write(input int addr, input logic [7:0] data, input logic ph);
        @(negedge clk);
        cpu_phase = ph;
        cpu_addr  = 10'(addr);
        cpu_data  = data;
        cpu_wr_n  = 1'b0;
        @(negedge clk);
        cpu_wr_n  = 1'b1;
        cpu_phase = 1'b1;
        if (!ph) shadow[addr] = data;
    endtask

    task automatic scan_line(input int v, input int bl_lo, input int bl_hi, input string req);
        int  ph = 0;
        logic pb = 1'b0;
        for (int h = 0; h <= 256; h++) begin
            @(negedge clk);
            if (h >= 3) check(req, pix_out, pb ? 1'b0 : exp_pix(ph, v));
            if (h < 256) begin
                cpu_phase = 1'b1;
                hcnt  = 8'(h);
                vcnt  = 8'(v);
                blank = (h >= bl_lo && h <= bl_hi);
                ph = h;
                pb = blank;
            end
        end
        blank = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 reset output", pix_out, 1'b0);
        end
    endtask

    task automatic t_fill_map;
        for (int a = 0; a < 1024; a++) begin
            cpu_write(a, 8'((a / 32) * 37 + (a % 32) * 11 + 3), 1'b0);
        end
    endtask

    task automatic t_normal_and_flip;
        for (int v = 0; v < 24; v++) scan_line(v, 1, 0, "R2 R4 R5 R6 R7 R8 map scan");
        scan_line(131, 1, 0, "R6 R7 mid screen");
        scan_line(255, 1, 0, "R6 R7 last line");
    endtask

    task automatic t_flip_pair;
        cpu_write(5 * 32 + 4, 8'h09, 1'b0);
        cpu_write(5 * 32 + 5, 8'h49, 1'b0);
        for (int v = 40; v < 48; v++) scan_line(v, 1, 0, "R7 mirrored pair");
    endtask

    task automatic t_ignored_bits;
        cpu_write(6 * 32 + 0, 8'h03, 1'b0);
        cpu_write(6 * 32 + 1, 8'hA3, 1'b0);
        cpu_write(6 * 32 + 2, 8'h43, 1'b0);
        cpu_write(6 * 32 + 3, 8'hE3, 1'b0);
        for (int v = 48; v < 56; v++) scan_line(v, 1, 0, "R10 bits 5 and 7");
    endtask

    task automatic t_video_phase_write;
        logic [7:0] nv;
        nv = ~shadow[2 * 32 + 5];
        cpu_write(2 * 32 + 5, nv, 1'b1);
        for (int v = 16; v < 24; v++) scan_line(v, 1, 0, "R3 write in video phase");
        cpu_write(2 * 32 + 5, nv, 1'b0);
        for (int v = 16; v < 24; v++) scan_line(v, 1, 0, "R2 write in cpu phase");
    endtask

    task automatic t_blank;
        scan_line(9, 100, 140, "R9 blank window");
        scan_line(10, 0, 255, "R9 full blank");
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_map();
        t_normal_and_flip();
        t_flip_pair();
        t_ignored_bits();
        t_video_phase_write();
        t_blank();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule